// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block turns an asynchronous serial line into characters. It counts ticks of an enable that runs at sixteen times the bit rate. A falling edge on the line starts a check of the start bit. Each later bit is sampled once, at its centre. The block builds a character of five to eight bits, least significant bit first. It can check an optional parity bit and it always checks the first stop bit. It then places the result in a receive holding register and raises a ready flag.

The host reads the holding register by pulsing a one-cycle read strobe. That pulse clears the ready flag and the three error flags: parity, framing and overrun. The oversampling enable comes from one of two sources: the shared bit-rate enable or an external clock enable, chosen by a select input. The serial input must already be synchronous to `clk`. Configuration inputs must stay stable while a character is being received.

Top module: `serial_rx_core`

## Requirements
- R1: `rate_sel` = 0 takes `baud_tick16` as the oversampling enable, and `rate_sel` = 1 takes `ext_tick16`. The enable that is not selected has no effect.
- R2: A start is recognised when the line is low on a tick and was high on the previous tick. The start is accepted only if the line is still low on the eighth tick after that edge tick. A low pulse that has ended by then loads nothing and leaves `rx_full` at 0.
- R3: The first data bit is sampled sixteen ticks after the accepted start sample, and each following bit sixteen ticks later. The first data bit received lands in `rx_data` bit 0.
- R4: `word_len` selects the data bit count: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Bits of `rx_data` at and above the selected count read as 0.
- R5: With `par_en` = 1, one parity bit follows the data bits. It is used only for checking and is never stored. `err_parity` is set when the count of ones in the data and parity bits is odd with `par_odd` = 0, or even with `par_odd` = 1.
- R6: A first stop bit sampled low sets `err_frame`. The character is still loaded.
- R7: On the clock edge where the stop bit is sampled, the character moves into `rx_data` and `rx_full` becomes 1. A `rd_strobe` pulse with no character completing clears `rx_full`, `err_parity`, `err_frame` and `err_overrun`. `rx_data` is kept.
- R8: A character that completes while `rx_full` is 1 and no read is strobed is discarded. `rx_data` and the parity and framing flags keep the older character, and `err_overrun` becomes 1.
- R9: A read strobe in the same cycle as a character completion is served first. The new character is loaded, `rx_full` stays 1 and `err_overrun` stays 0.
- R10: After reset, `rx_data` is 0 and `rx_full`, `err_parity`, `err_frame` and `err_overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick16 | input | 1 | Oversampling enable from the shared rate source |
| ext_tick16 | input | 1 | Oversampling enable derived from an external clock |
| rate_sel | input | 1 | 0 picks `baud_tick16`, 1 picks `ext_tick16` |
| rxd | input | 1 | Serial line, idle high, synchronous to `clk` |
| word_len | input | 2 | Data bit count code (5 + code) |
| par_en | input | 1 | Expect a parity bit |
| par_odd | input | 1 | 1 for odd parity, 0 for even |
| rd_strobe | input | 1 | One-cycle host read of the holding register |
| rx_data | output | 8 | Holding register, zero-filled above the word length |
| rx_full | output | 1 | Holding register contains an unread character |
| err_parity | output | 1 | Parity mismatch on the held character |
| err_frame | output | 1 | Stop bit of the held character sampled low |
| err_overrun | output | 1 | A character was lost because the register was full |

## Verification
A host read can fall on the same clock edge as a character completion. This is the collision where read-clearing and loading compete for the same flags. The bench provokes it by watching its own timing model. When the next selected tick will sample the final stop bit while an unread character is held, the bench drives the read strobe for exactly that cycle. The outcome is judged on the following cycle: the new character must be present, `rx_full` must remain set and `err_overrun` must be clear. The same sequence without the read, used elsewhere, must instead raise `err_overrun` and keep the old character.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_phase_e;

  // Data bit count selected by the two-bit length code (5..8).
  function automatic logic [3:0] char_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  // Parity mismatch: data_xor is the XOR of all received data bits.
  function automatic logic parity_bad(input logic en, input logic odd,
                                      input logic data_xor, input logic pbit);
    return en & (data_xor ^ pbit ^ odd);
  endfunction

endpackage

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rxd,
  input  logic [IDX_W:0]   n_bits,
  input  logic             par_en,
  output logic             evt_edge,
  output logic             evt_start_ok,
  output logic             evt_start_bad,
  output logic             evt_data,
  output logic [IDX_W-1:0] data_idx,
  output logic             evt_par,
  output logic             evt_stop
);

  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);

  rx_phase_e        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic             line_prev;
  logic             at_mid;
  logic             at_bit;
  logic             last_data;

  always_comb begin
    at_mid        = tick && (state == RX_START) && (cnt == MID_CNT);
    at_bit        = tick && (cnt == LAST_CNT) &&
                    (state inside {RX_DATA, RX_PAR, RX_STOP});
    evt_edge      = tick && (state == RX_IDLE) && line_prev && !rxd;
    evt_start_ok  = at_mid && !rxd;
    evt_start_bad = at_mid && rxd;
    evt_data      = at_bit && (state == RX_DATA);
    evt_par       = at_bit && (state == RX_PAR);
    evt_stop      = at_bit && (state == RX_STOP);
    last_data     = ({1'b0, idx} == (n_bits - 1'b1));
    data_idx      = idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      idx       <= '0;
      line_prev <= 1'b1;
    end else if (tick) begin
      line_prev <= rxd;
      unique case (state)
        RX_IDLE: begin
          cnt <= '0;
          if (evt_edge) state <= RX_START;
        end
        RX_START: begin
          if (at_mid) begin
            cnt   <= '0;
            idx   <= '0;
            state <= rxd ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (at_bit) begin
            cnt <= '0;
            idx <= idx + 1'b1;
            if (last_data) state <= par_en ? RX_PAR : RX_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_PAR: begin
          if (at_bit) begin
            cnt   <= '0;
            state <= RX_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (at_bit) begin
            cnt   <= '0;
            state <= RX_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rx_char_assembler.sv
module rx_char_assembler
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              evt_start_ok,
  input  logic              evt_data,
  input  logic [IDX_W-1:0]  data_idx,
  input  logic              evt_par,
  input  logic              evt_stop,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              frame_done,
  output logic [DATA_W-1:0] frm_data,
  output logic              frm_perr,
  output logic              frm_ferr
);

  logic [DATA_W-1:0] shreg;
  logic              acc;
  logic              pbit;

  // Each data bit is written into its own position, so the bits above the
  // word length keep the zeros loaded at the start sample.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      acc   <= 1'b0;
      pbit  <= 1'b0;
    end else if (evt_start_ok) begin
      shreg <= '0;
      acc   <= 1'b0;
      pbit  <= 1'b0;
    end else if (evt_data) begin
      shreg[data_idx] <= rxd;
      acc             <= acc ^ rxd;
    end else if (evt_par) begin
      pbit <= rxd;
    end
  end

  always_comb begin
    frame_done = evt_stop;
    frm_data   = shreg;
    frm_perr   = parity_bad(par_en, par_odd, acc, pbit);
    frm_ferr   = !rxd;
  end

endmodule

// File: rtl/rx_holding_reg.sv
module rx_holding_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_perr,
  input  logic              frm_ferr,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun
);

  logic accept;

  // A read in the completion cycle frees the register before the load.
  assign accept = frame_done && (!rx_full || rd_strobe);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_full     <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end else if (accept) begin
      rx_data     <= frm_data;
      rx_full     <= 1'b1;
      err_parity  <= frm_perr;
      err_frame   <= frm_ferr;
      err_overrun <= 1'b0;
    end else if (frame_done) begin
      err_overrun <= 1'b1;
    end else if (rd_strobe) begin
      rx_full     <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end
  end

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick16,
  input  logic              ext_tick16,
  input  logic              rate_sel,
  input  logic              rxd,
  input  logic [1:0]        word_len,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun
);

  localparam int IDX_W = $clog2(DATA_W);

  logic              tick_sel;
  logic [IDX_W:0]    n_bits;
  logic              evt_edge;
  logic              evt_start_ok;
  logic              evt_start_bad;
  logic              evt_data;
  logic [IDX_W-1:0]  data_idx;
  logic              evt_par;
  logic              evt_stop;
  logic              frame_done;
  logic [DATA_W-1:0] frm_data;
  logic              frm_perr;
  logic              frm_ferr;

  assign tick_sel = rate_sel ? ext_tick16 : baud_tick16;
  assign n_bits   = (IDX_W + 1)'(char_bits(word_len));

  rx_frame_fsm #(.OVS(OVS), .IDX_W(IDX_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick_sel),
    .rxd          (rxd),
    .n_bits       (n_bits),
    .par_en       (par_en),
    .evt_edge     (evt_edge),
    .evt_start_ok (evt_start_ok),
    .evt_start_bad(evt_start_bad),
    .evt_data     (evt_data),
    .data_idx     (data_idx),
    .evt_par      (evt_par),
    .evt_stop     (evt_stop)
  );

  rx_char_assembler #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_asm (
    .clk         (clk),
    .rst_n       (rst_n),
    .rxd         (rxd),
    .evt_start_ok(evt_start_ok),
    .evt_data    (evt_data),
    .data_idx    (data_idx),
    .evt_par     (evt_par),
    .evt_stop    (evt_stop),
    .par_en      (par_en),
    .par_odd     (par_odd),
    .frame_done  (frame_done),
    .frm_data    (frm_data),
    .frm_perr    (frm_perr),
    .frm_ferr    (frm_ferr)
  );

  rx_holding_reg #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .frm_data   (frm_data),
    .frm_perr   (frm_perr),
    .frm_ferr   (frm_ferr),
    .rd_strobe  (rd_strobe),
    .rx_data    (rx_data),
    .rx_full    (rx_full),
    .err_parity (err_parity),
    .err_frame  (err_frame),
    .err_overrun(err_overrun)
  );

endmodule

// File: rtl/rx_core_checks.sv
module rx_core_checks #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_strobe,
  input logic              frame_done,
  input logic              evt_start_bad,
  input logic [1:0]        word_len,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_full,
  input logic              err_parity,
  input logic              err_frame,
  input logic              err_overrun
);

  p_done_sets_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> rx_full);

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !frame_done) |=>
      (!rx_full && !err_parity && !err_frame && !err_overrun));

  p_overrun_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_full && !rd_strobe) |=>
      (err_overrun && rx_full && $stable(rx_data)));

  p_read_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rd_strobe) |=> (rx_full && !err_overrun));

  p_false_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_start_bad && !rd_strobe) |=> ($stable(rx_full) && $stable(rx_data)));

  p_zero_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> ((rx_data >> (32'd5 + 32'(word_len))) == '0));

endmodule

bind serial_rx_core rx_core_checks #(.DATA_W(DATA_W)) u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_strobe    (rd_strobe),
  .frame_done   (frame_done),
  .evt_start_bad(evt_start_bad),
  .word_len     (word_len),
  .rx_data      (rx_data),
  .rx_full      (rx_full),
  .err_parity   (err_parity),
  .err_frame    (err_frame),
  .err_overrun  (err_overrun)
);

// File: tb/tb_serial_rx_core.sv
module tb_serial_rx_core;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick16 = 1'b0;
  logic       ext_tick16 = 1'b0;
  logic       rate_sel;
  logic       rxd;
  logic [1:0] word_len;
  logic       par_en;
  logic       par_odd;
  logic       rd_strobe;
  logic [7:0] rx_data;
  logic       rx_full;
  logic       err_parity;
  logic       err_frame;
  logic       err_overrun;

  int compared   = 0;
  int mismatched = 0;
  bit started    = 0;
  int gcnt       = 0;

  always #4 clk = ~clk;

  serial_rx_core dut (
    .clk(clk), .rst_n(rst_n), .baud_tick16(baud_tick16), .ext_tick16(ext_tick16),
    .rate_sel(rate_sel), .rxd(rxd), .word_len(word_len), .par_en(par_en),
    .par_odd(par_odd), .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_full(rx_full),
    .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun)
  );

  // Two tick sources: period 4 on the rate enable, period 3 on the external one.
  always @(negedge clk) begin
    gcnt++;
    baud_tick16 = (gcnt % 4 == 0);
    ext_tick16  = (gcnt % 3 == 0);
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit         m_busy, m_prev, m_full, m_pe, m_fe, m_ovr;
  int         m_ticks;
  bit         q[$];
  logic [7:0] m_data;
  bit         tk, fin;
  int         ones, nb;
  logic [7:0] nd;

  function automatic int frame_len();
    return 7 + int'(word_len) + int'(par_en);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_prev = 1; m_ticks = 0; q.delete();
      m_data = 0; m_full = 0; m_pe = 0; m_fe = 0; m_ovr = 0;
    end else begin
      tk  = rate_sel ? ext_tick16 : baud_tick16;
      fin = 0;
      if (tk) begin
        if (!m_busy) begin
          if (m_prev && !rxd) begin
            m_busy = 1; m_ticks = 0; q.delete();
          end
        end else begin
          m_ticks++;
          if (m_ticks >= 8 && ((m_ticks - 8) % 16) == 0) begin
            q.push_back(rxd);
            if (q.size() == 1 && rxd) m_busy = 0;
            else if (q.size() == frame_len()) begin
              fin = 1; m_busy = 0;
            end
          end
        end
        m_prev = rxd;
      end
      if (fin) begin
        nb = 5 + int'(word_len);
        nd = 0; ones = 0;
        for (int i = 0; i < nb; i++) begin
          nd[i] = q[1 + i];
          ones += int'(q[1 + i]);
        end
        if (par_en) ones += int'(q[1 + nb]);
        if (!m_full || rd_strobe) begin
          m_data = nd; m_full = 1;
          m_pe = par_en && ((ones % 2) == (par_odd ? 0 : 1));
          m_fe = !q[q.size() - 1];
          m_ovr = 0;
        end else begin
          m_ovr = 1;
        end
      end else if (rd_strobe) begin
        m_full = 0; m_pe = 0; m_fe = 0; m_ovr = 0;
      end
    end
  end

  // Compare against the model on every clock, away from the active edge.
  always @(negedge clk) begin
    if (started && rst_n) begin
      chk("R3", "rx_data", 32'(rx_data), 32'(m_data));
      chk("R7", "rx_full", 32'(rx_full), 32'(m_full));
      chk("R5", "err_parity", 32'(err_parity), 32'(m_pe));
      chk("R6", "err_frame", 32'(err_frame), 32'(m_fe));
      chk("R8", "err_overrun", 32'(err_overrun), 32'(m_ovr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drive_bit(input bit v, input int per);
    @(negedge clk);
    rxd = v;
    repeat (16 * per - 1) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int n, input bit pen,
                            input bit pbit, input bit stopv, input int per);
    drive_bit(1'b0, per);
    for (int i = 0; i < n; i++) drive_bit(d[i], per);
    if (pen) drive_bit(pbit, per);
    drive_bit(stopv, per);
    drive_bit(1'b1, per);
    drive_bit(1'b1, per);
  endtask

  function automatic bit par_of(input logic [7:0] d, input int n, input bit odd);
    int c = 0;
    for (int i = 0; i < n; i++) c += int'(d[i]);
    return bit'(c % 2) ^ odd;
  endfunction

  task automatic host_read();
    @(negedge clk);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic read_on_completion();
    bit hit = 0;
    while (!hit) begin
      @(negedge clk);
      #1;
      if (m_busy && (rate_sel ? ext_tick16 : baud_tick16) &&
          (m_ticks + 1 == 8 + 16 * (frame_len() - 1))) begin
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        hit = 1;
      end
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; rate_sel = 0; rxd = 1; word_len = 2'd3;
    par_en = 0; par_odd = 0; rd_strobe = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    started = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "rx_data", 32'(rx_data), 32'h0);
    chk("R10", "flags", 32'({rx_full, err_parity, err_frame, err_overrun}), 32'h0);

    // R3/R7: 8 data bits, no parity
    send_frame(8'hA5, 8, 0, 0, 1, 4);
    chk("R3", "lsb-first data", 32'(rx_data), 32'hA5);
    chk("R7", "full after load", 32'(rx_full), 32'h1);
    host_read();
    @(negedge clk);
    chk("R7", "full after read", 32'(rx_full), 32'h0);
    chk("R7", "data kept after read", 32'(rx_data), 32'hA5);

    // R4/R5: 5 data bits, even parity correct, high bits zero
    word_len = 2'd0; par_en = 1; par_odd = 0;
    send_frame(8'hF6, 5, 1, par_of(8'hF6, 5, 0), 1, 4);
    chk("R4", "5-bit zero fill", 32'(rx_data), 32'h16);
    chk("R5", "even parity ok", 32'(err_parity), 32'h0);
    host_read();

    // R5: 7 bits, odd parity, wrong parity bit
    word_len = 2'd2; par_odd = 1;
    send_frame(8'h55, 7, 1, !par_of(8'h55, 7, 1), 1, 4);
    chk("R5", "odd parity error", 32'(err_parity), 32'h1);
    chk("R5", "parity stripped", 32'(rx_data), 32'h55);
    host_read();
    @(negedge clk);
    chk("R7", "parity flag cleared", 32'(err_parity), 32'h0);

    // R5: odd parity correct
    send_frame(8'h2B, 7, 1, par_of(8'h2B, 7, 1), 1, 4);
    chk("R5", "odd parity ok", 32'(err_parity), 32'h0);
    chk("R4", "7-bit data", 32'(rx_data), 32'h2B);
    host_read();

    // R6: framing error, character still stored
    word_len = 2'd3; par_en = 0;
    send_frame(8'h81, 8, 0, 0, 0, 4);
    chk("R6", "framing flag", 32'(err_frame), 32'h1);
    chk("R6", "data stored", 32'(rx_data), 32'h81);
    host_read();
    @(negedge clk);
    chk("R7", "framing cleared", 32'(err_frame), 32'h0);

    // R8: overrun keeps the older character
    send_frame(8'h3C, 8, 0, 0, 1, 4);
    send_frame(8'hC3, 8, 0, 0, 1, 4);
    chk("R8", "old data kept", 32'(rx_data), 32'h3C);
    chk("R8", "overrun flag", 32'(err_overrun), 32'h1);
    host_read();
    @(negedge clk);
    chk("R8", "overrun cleared", 32'(err_overrun), 32'h0);

    // R2: short low pulse rejected, then a real character
    @(negedge clk);
    rxd = 0;
    repeat (12) @(negedge clk);
    rxd = 1;
    repeat (16 * 4 * 12) @(negedge clk);
    chk("R2", "glitch ignored", 32'(rx_full), 32'h0);
    send_frame(8'h5A, 8, 0, 0, 1, 4);
    chk("R2", "valid start after glitch", 32'(rx_data), 32'h5A);
    host_read();

    // R1: external tick source at period 3
    rate_sel = 1;
    send_frame(8'h96, 8, 0, 0, 1, 3);
    chk("R1", "external source data", 32'(rx_data), 32'h96);
    chk("R1", "external source full", 32'(rx_full), 32'h1);
    host_read();

    // R9: read coincides with completion while full
    send_frame(8'h11, 8, 0, 0, 1, 3);
    fork
      send_frame(8'h22, 8, 0, 0, 1, 3);
      read_on_completion();
    join
    chk("R9", "new data loaded", 32'(rx_data), 32'h22);
    chk("R9", "full kept", 32'(rx_full), 32'h1);
    chk("R9", "no overrun", 32'(err_overrun), 32'h0);
    host_read();

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule